// File: doc/BRIEF.md
# Frame Buffer Refresh Address Generator

This block produces the linear frame-buffer read addresses for one screen refresh. Software sets the picture width, height and total pixel count through a 16-bit register write port. It also sets three scan-order controls. The first mirrors each row horizontally. The second mirrors the picture vertically. The third swaps the traversal between row-major and column-major. A single-cycle start pulse launches a refresh. The block then offers one address per cycle on a ready/valid output and flags the final address of the frame.

The display path uses the flags to show a picture rotated or mirrored without rewriting the buffer. A software-loaded refresh down-counter steps down once at the end of each completed refresh. When it reaches zero it raises a sticky interrupt flag, so software can wait a chosen number of frames.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `addr_last` and `irq_flag` are low and `refr_count` is zero.
- R2: A start pulse while idle, with width, height and size all non-zero, makes `addr_valid` high on the next cycle. Exactly `size` addresses are then emitted, and the last one has `addr_last` high. After it is accepted, `addr_valid` falls. A start pulse with any of the three equal to zero is ignored.
- R3: With all scan controls clear, the k-th address is `y*width + x`. Here x = k mod width and y = k div width, so the scan runs left to right along rows, top row first.
- R4: Configuration bit 2 (X mirror) replaces x by `width-1-x`.
- R5: Configuration bit 1 (Y mirror) replaces y by `height-1-y`.
- R6: Configuration bit 0 (transpose) makes y the inner index: y = k mod height and x = k div height. The mirrors still apply.
- R7: An address is consumed only when `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, `addr_out` and `addr_last` hold.
- R8: Width, height, size and scan controls are captured at the start pulse. Register writes during a refresh do not alter it.
- R9: A start pulse while a refresh is running is ignored.
- R10: Select 5 loads the refresh counter, which is visible on `refr_count`. It decrements by one when the last address of a refresh is accepted, and it stays at zero rather than wrapping.
- R11: `irq_flag` is set when the counter steps from 1 to 0. It stays set until a write to select 6 with data bit 0 high. A counter already at zero does not set it again.
- R12: Bits 15..3 of the configuration write are reserved and have no effect on the scan.

Register selects on `wr_sel`: 0 width, 1 height, 2 size bits 15..0, 3 size bits 31..16, 4 scan configuration, 5 refresh counter, 6 interrupt clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| start | input | 1 | Refresh launch pulse |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | Address is available |
| addr_out | output | 32 | Linear frame-buffer address |
| addr_last | output | 1 | Final address of the refresh |
| refr_count | output | 16 | Current refresh counter value |
| irq_flag | output | 1 | Sticky refresh-complete interrupt flag |

## Verification
The bench runs all eight scan-control combinations on a non-square 4x3 picture. Its expected addresses come from its own index arithmetic. A design that mixed up width and height, or mirrored with the wrong extent, would emit out-of-order or out-of-frame addresses there. A stalled consumer, writes issued mid-frame and a second start pulse check that addresses neither skip nor change under a running refresh. A short size value and a zero size check that the frame length follows the size register and that an empty frame never starts. The counter is driven down to zero and then past it, to catch wrapping, a flag that refires, or a flag that does not stick until cleared.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_WIDTH   = 3'd0,
    SEL_HEIGHT  = 3'd1,
    SEL_SIZE_LO = 3'd2,
    SEL_SIZE_HI = 3'd3,
    SEL_CFG     = 3'd4,
    SEL_REFR    = 3'd5,
    SEL_IRQ_CLR = 3'd6
  } reg_sel_e;

  localparam int CFG_TRANSPOSE_BIT = 0;
  localparam int CFG_YMIR_BIT      = 1;
  localparam int CFG_XMIR_BIT      = 2;

  typedef struct packed {
    logic x_mir;
    logic y_mir;
    logic transpose;
  } scan_cfg_t;
endpackage

// File: rtl/fbs_rst_sync.sv
module fbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fbs_cfg_regs.sv
module fbs_cfg_regs
  import fbs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int SIZE_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] width,
  output logic [DATA_W-1:0] height,
  output logic [SIZE_W-1:0] size,
  output scan_cfg_t         cfg
);
  logic [DATA_W-1:0] width_d, height_d, size_lo_d, size_hi_d;
  logic [DATA_W-1:0] width_q, height_q, size_lo_q, size_hi_q;
  scan_cfg_t         cfg_d, cfg_q;

  always_comb begin
    width_d   = width_q;
    height_d  = height_q;
    size_lo_d = size_lo_q;
    size_hi_d = size_hi_q;
    cfg_d     = cfg_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_WIDTH:   width_d   = wr_data;
        SEL_HEIGHT:  height_d  = wr_data;
        SEL_SIZE_LO: size_lo_d = wr_data;
        SEL_SIZE_HI: size_hi_d = wr_data;
        SEL_CFG: begin
          cfg_d.transpose = wr_data[CFG_TRANSPOSE_BIT];
          cfg_d.y_mir     = wr_data[CFG_YMIR_BIT];
          cfg_d.x_mir     = wr_data[CFG_XMIR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q   <= '0;
      height_q  <= '0;
      size_lo_q <= '0;
      size_hi_q <= '0;
      cfg_q     <= '0;
    end else if (wr_en) begin
      width_q   <= width_d;
      height_q  <= height_d;
      size_lo_q <= size_lo_d;
      size_hi_q <= size_hi_d;
      cfg_q     <= cfg_d;
    end
  end

  assign width  = width_q;
  assign height = height_q;
  assign size   = {size_hi_q, size_lo_q};
  assign cfg    = cfg_q;

  a_r12_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_CFG) |=> $stable(cfg_q));
endmodule

// File: rtl/fbs_scan_core.sv
module fbs_scan_core
  import fbs_pkg::*;
#(
  parameter int DIM_W = 16,
  localparam int ADDR_W = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [ADDR_W-1:0] size,
  input  scan_cfg_t         cfg,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_last,
  output logic              frame_done
);
  logic              busy_q, busy_d;
  logic [DIM_W-1:0]  w_q, w_d, h_q, h_d;
  logic [ADDR_W-1:0] size_q, size_d;
  scan_cfg_t         cfg_q, cfg_d;
  logic [DIM_W-1:0]  in_q, in_d, out_q, out_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;

  logic [DIM_W-1:0]  in_max, x_raw, y_raw, x_eff, y_eff;
  logic              last, fire, launch;
  logic              upd;

  assign launch = !busy_q && start && (size != '0) && (width != '0) && (height != '0);
  assign fire   = busy_q && addr_ready;
  assign last   = (cnt_q == size_q - ADDR_W'(1));
  assign upd    = launch || fire;

  assign in_max = cfg_q.transpose ? (h_q - DIM_W'(1)) : (w_q - DIM_W'(1));
  assign x_raw  = cfg_q.transpose ? out_q : in_q;
  assign y_raw  = cfg_q.transpose ? in_q  : out_q;
  assign x_eff  = cfg_q.x_mir ? (w_q - DIM_W'(1) - x_raw) : x_raw;
  assign y_eff  = cfg_q.y_mir ? (h_q - DIM_W'(1) - y_raw) : y_raw;

  always_comb begin
    busy_d = busy_q;
    w_d    = w_q;
    h_d    = h_q;
    size_d = size_q;
    cfg_d  = cfg_q;
    in_d   = in_q;
    out_d  = out_q;
    cnt_d  = cnt_q;
    if (launch) begin
      busy_d = 1'b1;
      w_d    = width;
      h_d    = height;
      size_d = size;
      cfg_d  = cfg;
      in_d   = '0;
      out_d  = '0;
      cnt_d  = '0;
    end else if (fire) begin
      if (last) begin
        busy_d = 1'b0;
      end
      cnt_d = cnt_q + ADDR_W'(1);
      if (in_q == in_max) begin
        in_d  = '0;
        out_d = out_q + DIM_W'(1);
      end else begin
        in_d = in_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      w_q    <= '0;
      h_q    <= '0;
      size_q <= '0;
      cfg_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      w_q    <= w_d;
      h_q    <= h_d;
      size_q <= size_d;
      cfg_q  <= cfg_d;
      in_q   <= in_d;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_valid = busy_q;
  assign addr_out   = {{DIM_W{1'b0}}, y_eff} * {{DIM_W{1'b0}}, w_q} + {{DIM_W{1'b0}}, x_eff};
  assign addr_last  = busy_q && last;
  assign frame_done = fire && last;

  a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(addr_out) && $stable(addr_last));
  a_r2_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && addr_last |=> !addr_valid);
  a_r2_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    addr_last |-> addr_valid);
  a_r3_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && (cnt_q < {{DIM_W{1'b0}}, w_q} * {{DIM_W{1'b0}}, h_q})
      |-> addr_out < {{DIM_W{1'b0}}, w_q} * {{DIM_W{1'b0}}, h_q});
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> $stable(cnt_q));
endmodule

// File: rtl/fbs_refr_cnt.sv
module fbs_refr_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_clr,
  input  logic             frame_done,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             step, cnt_en, irq_en;

  assign step   = frame_done && !load && (cnt_q != '0);
  assign cnt_en = load || step;
  assign irq_en = irq_clr || step;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    irq_d = irq_q;
    if (step && cnt_q == CNT_W'(1)) irq_d = 1'b1;
    else if (irq_clr)               irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  a_r10_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !frame_done |=> $stable(cnt_q));
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !load && cnt_q == '0 |=> cnt_q == '0);
  a_r11_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> cnt_q == '0);
  a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
  import fbs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic              addr_ready,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_last,
  output logic [CNT_W-1:0]  refr_count,
  output logic              irq_flag
);
  logic              rst_n_s;
  logic [DATA_W-1:0] width, height;
  logic [ADDR_W-1:0] size;
  scan_cfg_t         cfg;
  logic              frame_done;
  logic              cnt_load, irq_clr;

  fbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  fbs_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .width(width), .height(height), .size(size), .cfg(cfg)
  );

  fbs_scan_core #(.DIM_W(DATA_W)) u_scan (
    .clk(clk), .rst_n(rst_n_s), .start(start), .width(width), .height(height),
    .size(size), .cfg(cfg), .addr_ready(addr_ready), .addr_valid(addr_valid),
    .addr_out(addr_out), .addr_last(addr_last), .frame_done(frame_done)
  );

  assign cnt_load = wr_en && (wr_sel == SEL_REFR);
  assign irq_clr  = wr_en && (wr_sel == SEL_IRQ_CLR) && wr_data[0];

  fbs_refr_cnt #(.CNT_W(CNT_W)) u_refr (
    .clk(clk), .rst_n(rst_n_s), .load(cnt_load), .load_val(wr_data[CNT_W-1:0]),
    .irq_clr(irq_clr), .frame_done(frame_done), .count(refr_count), .irq(irq_flag)
  );
endmodule

// File: tb/test_fb_scan_addr_gen.sv
`timescale 1ns/1ps
module test_fb_scan_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        addr_ready = 1'b0;
  logic        addr_valid;
  logic [31:0] addr_out;
  logic        addr_last;
  logic [15:0] refr_count;
  logic        irq_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fb_scan_addr_gen i_fb_scan_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .addr_ready(addr_ready), .addr_valid(addr_valid),
    .addr_out(addr_out), .addr_last(addr_last), .refr_count(refr_count),
    .irq_flag(irq_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic setup(input int w, input int h, input int sz, input int cfg);
    wr(0, w); wr(1, h); wr(2, sz & 16'hFFFF); wr(3, sz >> 16); wr(4, cfg);
  endtask

  function automatic int exp_addr(input int w, input int h, input int cfg, input int k);
    int inner, i, o, x, y;
    inner = cfg[0] ? h : w;
    i = k % inner;
    o = k / inner;
    x = cfg[0] ? o : i;
    y = cfg[0] ? i : o;
    if (cfg[2]) x = w - 1 - x;
    if (cfg[1]) y = h - 1 - y;
    return y * w + x;
  endfunction

  // Collects n addresses after a start; stall != 0 drops ready two cycles in three.
  task automatic collect(input string req, input int w, input int h, input int cfg,
                         input int n, input int stall);
    int idx = 0;
    int guard = 0;
    int bad = 0;
    logic        held = 1'b0;
    logic [31:0] held_addr = '0;
    while (idx < n && guard < 2000) begin
      @(negedge clk);
      guard++;
      addr_ready = (stall != 0) ? ((guard % 3) == 0) : 1'b1;
      #1;
      if (held) begin
        check("R7 held address", addr_out, held_addr);
      end
      held = 1'b0;
      if (addr_valid && addr_ready) begin
        if (addr_out !== 32'(exp_addr(w, h, cfg, idx)) ||
            addr_last !== (idx == n - 1)) begin
          bad++;
          $display("FAIL %s: index %0d actual %0d/%0b expected %0d/%0b", req, idx,
                   addr_out, addr_last, exp_addr(w, h, cfg, idx), (idx == n - 1));
        end
        idx++;
      end else if (addr_valid) begin
        held = 1'b1;
        held_addr = addr_out;
      end
    end
    n_tests++;
    if (bad != 0) n_fail++;
    check({req, " count"}, 32'(idx), 32'(n));
    @(negedge clk);
    addr_ready = 1'b0;
    #1;
    check("R2 idle after last", {31'b0, addr_valid}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 valid", {31'b0, addr_valid}, 0);
    check("R1 last", {31'b0, addr_last}, 0);
    check("R1 irq", {31'b0, irq_flag}, 0);
    check("R1 count", {16'b0, refr_count}, 0);
  endtask

  task automatic t_orders();
    for (int c = 0; c < 8; c++) begin
      setup(4, 3, 12, c);
      pulse_start();
      check("R2 valid after start", {31'b0, addr_valid}, 1);
      collect($sformatf("R3/R4/R5/R6 cfg %0d", c), 4, 3, c, 12, 0);
    end
  endtask

  task automatic t_reserved();
    setup(4, 3, 12, 16'hFFF8);
    pulse_start();
    collect("R12 reserved bits cfg 0", 4, 3, 0, 12, 0);
    setup(4, 3, 12, 16'hFFFD);
    pulse_start();
    collect("R12 reserved bits cfg 5", 4, 3, 5, 12, 0);
  endtask

  task automatic t_backpressure();
    setup(3, 5, 15, 3);
    pulse_start();
    collect("R7 stalled frame", 3, 5, 3, 15, 1);
  endtask

  task automatic t_midframe();
    setup(4, 3, 12, 0);
    pulse_start();
    wr(4, 7); wr(0, 2); wr(2, 3);
    pulse_start();
    check("R8 still first addr", addr_out, 0);
    collect("R8/R9 mid-frame writes", 4, 3, 0, 12, 0);
  endtask

  task automatic t_sizes();
    setup(4, 3, 5, 6);
    pulse_start();
    collect("R2 short size", 4, 3, 6, 5, 0);
    setup(4, 3, 0, 0);
    pulse_start();
    repeat (3) @(negedge clk);
    check("R2 zero size ignored", {31'b0, addr_valid}, 0);
  endtask

  task automatic t_refresh();
    setup(2, 2, 4, 0);
    wr(5, 2);
    check("R10 load", {16'b0, refr_count}, 2);
    pulse_start(); collect("R10 frame a", 2, 2, 0, 4, 0);
    check("R10 dec to 1", {16'b0, refr_count}, 1);
    check("R11 irq not yet", {31'b0, irq_flag}, 0);
    pulse_start(); collect("R10 frame b", 2, 2, 0, 4, 0);
    check("R10 dec to 0", {16'b0, refr_count}, 0);
    check("R11 irq set", {31'b0, irq_flag}, 1);
    pulse_start(); collect("R10 frame c", 2, 2, 0, 4, 0);
    check("R10 no wrap", {16'b0, refr_count}, 0);
    check("R11 sticky", {31'b0, irq_flag}, 1);
    wr(6, 0);
    check("R11 write 0 keeps", {31'b0, irq_flag}, 1);
    wr(6, 1);
    check("R11 cleared", {31'b0, irq_flag}, 0);
    pulse_start(); collect("R10 frame d", 2, 2, 0, 4, 0);
    check("R11 no refire at zero", {31'b0, irq_flag}, 0);
    check("R10 stays zero", {16'b0, refr_count}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_orders();
    t_reserved();
    t_backpressure();
    t_midframe();
    t_sizes();
    t_refresh();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule